// File: doc/BRIEF.md
# Overlapping Six-Bit Serial Pattern Detector

This block watches a single serial data line that is sampled once per rising clock edge. It raises a one-bit hit signal whenever the six most recent bits, oldest first, read 0,1,1,0,1,1. Detection overlaps: the closing "011" of one hit also serves as the opening half of the next one. A continuous stream of repeated "011" groups therefore produces a hit on every third bit once the first six bits have arrived.

The detector is a Mealy machine. It has six progress states held in a three-bit binary register, plus combinational output logic. The hit output depends on the present state and the present input bit. It is valid in the same cycle as the final bit of the pattern and is not registered. A synchronous active-low reset clears all progress and holds the output low for as long as reset is asserted. The surrounding logic presents one bit per cycle and reads the hit output in that same cycle.

Top module: `twin_triplet_detector`

## Requirements
- R1: While rst_n is low, hit reads 0 whatever the value of bit_in and whatever progress the machine had made before.
- R2: A rising clock edge with rst_n low discards all earlier progress. After reset is released, a hit needs six fresh bits 0,1,1,0,1,1.
- R3: hit is combinational. In the cycle that presents the sixth bit of the pattern, hit goes high when bit_in is 1 and stays low when bit_in is 0, with no clock edge between the two.
- R4: After a hit, the trailing "011" counts toward the next match. The stream 011011011 hits on bits 6 and 9, and 011011011011 hits on bits 6, 9 and 12.
- R5: For every input stream, hit in a given cycle is 1 exactly when at least six bits have been accepted since reset and the last six, oldest first, equal 0,1,1,0,1,1.
- R6: Any run of leading 0s or 1s before the pattern does not prevent or delay the hit. Extra 0s keep the "seen 0" progress, and 1s with no preceding 0 make no progress.
- R7: A 1 arriving after "011" clears all progress, so 0111011 gives no hit. A 0 arriving after "0110" or "01101" keeps only the "seen 0" progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one bit is accepted per edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Serial data bit for the current cycle |
| hit | output | 1 | High in the cycle whose bit completes 0,1,1,0,1,1 |

## Verification
Every 12-bit stream, started fresh from reset, is compared bit by bit against a shift-register model. This covers every transition from every reachable state and every overlap position inside a 12-bit window. Directed streams separate specific behaviours:
- Repeated "011" groups test the fall-back to the "011" state after a hit.
- Streams with leading runs test the self-loops.
- 0111011 shows that a 1 after "011" clears progress.
- Toggling bit_in inside the final cycle shows that the output is combinational.

A reset applied in the state one bit short of a match, with bit_in held at 1, shows that reset both masks the output and clears progress.

// File: rtl/tt_pkg.sv
// Shared definitions for the twin-triplet serial detector.
// Assumes: the pattern is fixed, so the state set is fixed at six codes.
package tt_pkg;
    localparam int TT_STATE_W = 3;

    // Progress through 0,1,1,0,1,1; codes 6 and 7 are unused.
    typedef enum logic [TT_STATE_W-1:0] {
        ST_NONE  = 3'd0,  // no useful progress
        ST_Z     = 3'd1,  // seen 0
        ST_ZO    = 3'd2,  // seen 01
        ST_ZOO   = 3'd3,  // seen 011
        ST_ZOOZ  = 3'd4,  // seen 0110
        ST_ZOOZO = 3'd5   // seen 01101
    } tt_state_e;
endpackage

// File: rtl/tt_next_state.sv
// Next-state logic for the detector.
// Assumes: cur is a registered state; an unused code falls back to ST_NONE.
module tt_next_state
    import tt_pkg::*;
(
    input  tt_state_e cur,
    input  logic      din,
    output tt_state_e nxt
);
    // Transition table, including the fall-back to ST_ZOO after a hit.
    always_comb begin
        case (cur)
            ST_NONE:  nxt = din ? ST_NONE  : ST_Z;
            ST_Z:     nxt = din ? ST_ZO    : ST_Z;
            ST_ZO:    nxt = din ? ST_ZOO   : ST_Z;
            ST_ZOO:   nxt = din ? ST_NONE  : ST_ZOOZ;
            ST_ZOOZ:  nxt = din ? ST_ZOOZO : ST_Z;
            ST_ZOOZO: nxt = din ? ST_ZOO   : ST_Z;
            default:  nxt = ST_NONE;
        endcase
    end
endmodule

// File: rtl/tt_hit_decode.sv
// Mealy output decode: hit is a function of the state, the input and the run enable.
// Assumes: run is low while synchronous reset is asserted.
module tt_hit_decode
    import tt_pkg::*;
(
    input  tt_state_e cur,
    input  logic      din,
    input  logic      run,
    output logic      hit
);
    // Flag the final 1 of the pattern, masked while reset is asserted.
    always_comb begin
        hit = 1'b0;
        if (run && (cur == ST_ZOOZO) && din) hit = 1'b1;
    end
endmodule

// File: rtl/tt_state_reg.sv
// State register with synchronous active-low reset.
// Assumes: a single clock domain; reset is sampled on the rising edge.
module tt_state_reg
    import tt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tt_state_e nxt,
    output tt_state_e cur
);
    // Load the next state each edge, or clear progress under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= ST_NONE;
        else        cur <= nxt;
    end
endmodule

// File: rtl/twin_triplet_detector.sv
// Top of the overlapping 0,1,1,0,1,1 serial detector (Mealy machine).
// Assumes: one bit per clock on bit_in; hit is read in the same cycle.
module twin_triplet_detector
    import tt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic hit
);
    tt_state_e state_q;
    tt_state_e state_d;

    tt_next_state u_next (
        .cur (state_q),
        .din (bit_in),
        .nxt (state_d)
    );

    tt_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (state_d),
        .cur   (state_q)
    );

    tt_hit_decode u_dec (
        .cur (state_q),
        .din (bit_in),
        .run (rst_n),
        .hit (hit)
    );

    // Reset leaves the machine with no progress (R2).
    p_reset_clears_r2: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_NONE));

    // The output stays low whenever reset is asserted (R1).
    p_reset_masks_hit_r1: assert property (@(posedge clk)
        !rst_n |-> !hit);

    // Only the six legal codes are held out of reset (R5).
    p_legal_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q <= ST_ZOOZO));

    // After a hit the machine keeps the trailing 011 (R4).
    p_overlap_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (state_q == ST_ZOO));

    // A hit is preceded by the bits 0 then 1 (R5).
    p_hit_history_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(bit_in) == 1'b1) && ($past(bit_in, 2) == 1'b0));

    // A 0 outside state ST_ZOO leaves only "seen 0" progress (R7).
    p_zero_fallback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_in && (state_q != ST_ZOO)) |=> (state_q == ST_Z));

    // A 1 after 011 discards progress (R7).
    p_one_after_zoo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_in && (state_q == ST_ZOO)) |=> (state_q == ST_NONE));
endmodule

// File: tb/sim_twin_triplet_detector.sv
module sim_twin_triplet_detector;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic hit;
    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;
    logic [5:0] hist = '0;
    int   cnt = 0;

    always #5ns clk = ~clk;

    twin_triplet_detector u0 (.clk(clk), .rst_n(rst_n), .bit_in(bit_in), .hit(hit));

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Reset for one edge, checking the masked output with bit_in high (R1).
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_in = 1'b1;
        #1 check(hit, 1'b0, "R1 hit during reset");
        @(negedge clk);
        rst_n = 1'b1;
        hist = '0;
        cnt = 0;
    endtask

    // Drive one bit, check against the model, then let the edge accept it.
    task automatic send(input logic b, input string tag);
        logic [5:0] h;
        logic exp;
        @(negedge clk);
        bit_in = b;
        h = {hist[4:0], b};
        exp = (cnt >= 5) && (h == 6'b011011);
        #1 check(hit, exp, tag);
        hist = h;
        cnt++;
    endtask

    task automatic send_str(input string s, input string tag);
        for (int i = 0; i < s.len(); i++) send(s[i] == "1", tag);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R5 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        #1 check(hit, 1'b0, "R1 hit at start of reset");
        do_reset();

        // R4: overlapping matches at bits 6, 9 and 12.
        send_str("011011011011", "R4 repeated triplets");
        do_reset();
        send_str("011011011", "R4 nine-bit stream");

        // R6: leading runs of 0s and of 1s.
        do_reset();
        send_str("0000011011", "R6 leading zeros");
        do_reset();
        send_str("1111011011", "R6 leading ones");

        // R7: a 1 after 011 clears progress; a 0 after 0110 or 01101 restarts.
        do_reset();
        send_str("0111011", "R7 one after 011");
        send_str("0110011011", "R7 zero after 0110");
        send_str("01101011011", "R7 zero after 01101");

        // R3: the output follows bit_in within the final cycle.
        do_reset();
        send_str("01101", "R3 prefix");
        @(negedge clk);
        bit_in = 1'b0;
        #1 check(hit, 1'b0, "R3 final bit low");
        bit_in = 1'b1;
        #1 check(hit, 1'b1, "R3 final bit high");
        hist = {hist[4:0], 1'b1};
        cnt++;

        // R1 and R2: reset one bit short of a match masks the hit and clears progress.
        do_reset();
        send_str("01101", "R2 prefix");
        @(negedge clk);
        rst_n = 1'b0;
        bit_in = 1'b1;
        #1 check(hit, 1'b0, "R1 reset masks pending hit");
        @(negedge clk);
        rst_n = 1'b1;
        hist = '0;
        cnt = 0;
        send(1'b1, "R2 no hit after reset");
        send_str("011011", "R2 fresh match");

        // R5: every 12-bit stream from reset against the shift-register model.
        for (int w = 0; w < 4096; w++) begin
            do_reset();
            for (int k = 11; k >= 0; k--) send(w[k], "R5 sweep");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule